// File: doc/BRIEF.md
# Polled UART Receive Register Slice

This block sits between a UART receive engine and the processor bus when software collects incoming characters by polling instead of through a DMA channel. Each character handed over by the receive engine is held in a data register and marks a ready flag. Parity failures and lost characters are kept as sticky error bits. Two interrupt lines follow those flags, and each line has its own enable.

Software uses a plain register read port to collect the character, poll the ready flag and inspect the error bits. Reads have side effects: reading the character clears the ready flag, and reading the error register clears both error bits. A setup register holds the polling-mode enable. It also has a self-clearing flush control that throws away a held character. Read data comes back one cycle after the request, and all outputs are registered.

Top module: `uart_rx_poll_regs`

## Requirements
- R1: After a synchronous reset the ready flag, both error bits, both interrupt enables, the polling enable, the interrupts and `rd_data` are all 0.
- R2: A cycle with `rx_stb` high stores `rx_byte`. From the next cycle the ready flag (bit 0 at offset 0x30) reads 1. A read of offset 0x34 returns the stored byte, zero-extended, on `rd_data` in the cycle after the request.
- R3: A read of offset 0x34 clears the ready flag. A read of offset 0x30 leaves the ready flag unchanged.
- R4: If a character arrives while the ready flag is 1, and no read of 0x34 and no flush happens in that cycle, the new character replaces the old one and the overflow bit (bit 0 at offset 0x28) becomes 1.
- R5: A character that arrives with `rx_parity_bad` high sets the parity bit (bit 1 at offset 0x28). The character is still stored and still marks ready.
- R6: The error bits are sticky. Only a read of offset 0x28 clears them, and that read returns their values from before the clear.
- R7: When a hardware event and a clearing action fall in the same cycle, the hardware event wins. A character arriving together with a read of 0x34 leaves ready at 1 with the new byte, and no overflow is recorded. An error set together with a read of 0x28 leaves that error bit at 1.
- R8: `irq_rx` is high exactly while the ready flag is 1 and enable bit 0 at offset 0x2C is 1. `irq_err` is high exactly while an error bit is 1 and enable bit 1 at offset 0x2C is 1. Both outputs follow the flags in the same cycle.
- R9: Bit 4 of the setup register at offset 0x24 is the polling enable. It reads back and drives `poll_en`.
- R10: Writing 1 to bit 5 of offset 0x24 flushes the held character: ready goes to 0 and the data register becomes 0. Bit 5 always reads 0. A character arriving in the same cycle as the flush survives it.
- R11: Writes to offsets 0x28, 0x30 and 0x34 have no effect.
- R12: Reads of unmapped offsets return 0 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_stb | input | 1 | One-cycle strobe: a character is available from the receive engine |
| rx_byte | input | DATA_W | Received character |
| rx_parity_bad | input | 1 | The character on `rx_byte` failed its parity check |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | BUS_W | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | BUS_W | Read data, valid the cycle after the request |
| irq_rx | output | 1 | Character-ready interrupt |
| irq_err | output | 1 | Error interrupt |
| poll_en | output | 1 | Polling mode enable from the setup register |

## Verification
The bench targets same-cycle collisions. It drives a character together with a data read, a parity failure together with an error read, and a character together with a flush. A design where the clear wins would lose the character or the error. A design that counts the collided arrival as an overflow would report an error that never happened. The bench also reads the ready register several times in a row and writes to the read-only offsets. A design with a side effect on the wrong register would drop the ready flag or corrupt the stored byte. Finally, the bench checks each interrupt in the cycle its flag changes and reads the setup register right after a flush. A lagging interrupt register or a flush bit that stays set would show up there.

// File: rtl/uart_rxp_pkg.sv
package uart_rxp_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SETUP = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ERR   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_IE    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_RDY   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h34;

  localparam int BIT_OVF   = 0;
  localparam int BIT_PAR   = 1;
  localparam int BIT_IE_RX = 0;
  localparam int BIT_IE_ER = 1;
  localparam int BIT_POLL  = 4;
  localparam int BIT_FLUSH = 5;

  typedef struct packed {
    logic par;
    logic ovf;
  } err_flags_t;
endpackage

// File: rtl/uart_rxp_hold.sv
module uart_rxp_hold
  import uart_rxp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_par_bad,
  input  logic              rd_data_hit,
  input  logic              rd_err_hit,
  input  logic              flush,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output err_flags_t        err_q,
  output logic              valid_nx,
  output logic              err_any_nx
);
  logic [DATA_W-1:0] data_nx;
  err_flags_t        err_nx;

  always_comb begin
    valid_nx = valid_q;
    data_nx  = data_q;
    err_nx   = err_q;
    if (rd_data_hit || flush) valid_nx = 1'b0;
    if (flush) data_nx = '0;
    if (rx_stb) begin
      valid_nx = 1'b1;
      data_nx  = rx_byte;
    end
    if (rd_err_hit) err_nx = '0;
    if (rx_stb && valid_q && !rd_data_hit && !flush) err_nx.ovf = 1'b1;
    if (rx_stb && rx_par_bad) err_nx.par = 1'b1;
    err_any_nx = err_nx.ovf | err_nx.par;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= '0;
    end else begin
      data_q  <= data_nx;
      valid_q <= valid_nx;
      err_q   <= err_nx;
    end
  end

  assert_arrival_sets_ready_R7: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> valid_q);
  assert_data_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data_hit && !rx_stb) |=> !valid_q);
  assert_overflow_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && valid_q && !rd_data_hit && !flush) |=> err_q.ovf);
  assert_parity_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && rx_par_bad) |=> err_q.par);
  assert_sticky_ovf_R6: assert property (@(posedge clk) disable iff (rst)
    (err_q.ovf && !rd_err_hit) |=> err_q.ovf);
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    (flush && !rx_stb) |=> (!valid_q && data_q == '0));
endmodule

// File: rtl/uart_rxp_cfg.sv
module uart_rxp_cfg
  import uart_rxp_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              ie_rx_q,
  output logic              ie_err_q,
  output logic              ie_rx_nx,
  output logic              ie_err_nx,
  output logic              poll_q,
  output logic              flush
);
  logic wr_ie, wr_setup, poll_nx;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data;
  assign wr_ie    = wr_en && (wr_addr == OFS_IE);
  assign wr_setup = wr_en && (wr_addr == OFS_SETUP);
  assign flush    = wr_setup && wr_data[BIT_FLUSH];

  always_comb begin
    ie_rx_nx  = ie_rx_q;
    ie_err_nx = ie_err_q;
    poll_nx   = poll_q;
    if (wr_ie) begin
      ie_rx_nx  = wr_data[BIT_IE_RX];
      ie_err_nx = wr_data[BIT_IE_ER];
    end
    if (wr_setup) poll_nx = wr_data[BIT_POLL];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_rx_q  <= 1'b0;
      ie_err_q <= 1'b0;
      poll_q   <= 1'b0;
    end else begin
      ie_rx_q  <= ie_rx_nx;
      ie_err_q <= ie_err_nx;
      poll_q   <= poll_nx;
    end
  end

  assert_poll_written_R9: assert property (@(posedge clk) disable iff (rst)
    wr_setup |=> (poll_q == $past(wr_data[BIT_POLL])));
  assert_ie_held_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_ie |=> ($stable(ie_rx_q) && $stable(ie_err_q)));
endmodule

// File: rtl/uart_rxp_irq.sv
module uart_rxp_irq (
  input  logic clk,
  input  logic rst,
  input  logic valid_nx,
  input  logic err_any_nx,
  input  logic ie_rx_nx,
  input  logic ie_err_nx,
  input  logic valid_q,
  input  logic err_any_q,
  input  logic ie_rx_q,
  input  logic ie_err_q,
  output logic irq_rx,
  output logic irq_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_rx  <= valid_nx & ie_rx_nx;
      irq_err <= err_any_nx & ie_err_nx;
    end
  end

  assert_irq_rx_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    irq_rx == (valid_q & ie_rx_q));
  assert_irq_err_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    irq_err == (err_any_q & ie_err_q));
endmodule

// File: rtl/uart_rx_poll_regs.sv
module uart_rx_poll_regs
  import uart_rxp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_parity_bad,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [7:0]        rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              poll_en
);
  localparam int PAD_W = BUS_W - DATA_W;

  logic              rd_data_hit, rd_err_hit, flush;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, valid_nx, err_any_nx;
  err_flags_t        err_q;
  logic              ie_rx_q, ie_err_q, ie_rx_nx, ie_err_nx, poll_q;
  logic [BUS_W-1:0]  rd_mux;

  assign rd_data_hit = rd_en && (rd_addr == OFS_DATA);
  assign rd_err_hit  = rd_en && (rd_addr == OFS_ERR);

  uart_rxp_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .rx_par_bad(rx_parity_bad), .rd_data_hit(rd_data_hit),
    .rd_err_hit(rd_err_hit), .flush(flush), .data_q(data_q),
    .valid_q(valid_q), .err_q(err_q), .valid_nx(valid_nx),
    .err_any_nx(err_any_nx)
  );

  uart_rxp_cfg #(.BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ie_rx_q(ie_rx_q), .ie_err_q(ie_err_q),
    .ie_rx_nx(ie_rx_nx), .ie_err_nx(ie_err_nx), .poll_q(poll_q),
    .flush(flush)
  );

  uart_rxp_irq u_irq (
    .clk(clk), .rst(rst), .valid_nx(valid_nx), .err_any_nx(err_any_nx),
    .ie_rx_nx(ie_rx_nx), .ie_err_nx(ie_err_nx), .valid_q(valid_q),
    .err_any_q(err_q.ovf | err_q.par), .ie_rx_q(ie_rx_q),
    .ie_err_q(ie_err_q), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      OFS_DATA:  rd_mux = {{PAD_W{1'b0}}, data_q};
      OFS_RDY:   rd_mux[0] = valid_q;
      OFS_ERR: begin
        rd_mux[BIT_OVF] = err_q.ovf;
        rd_mux[BIT_PAR] = err_q.par;
      end
      OFS_IE: begin
        rd_mux[BIT_IE_RX] = ie_rx_q;
        rd_mux[BIT_IE_ER] = ie_err_q;
      end
      OFS_SETUP: rd_mux[BIT_POLL] = poll_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign poll_en = poll_q;

  assert_flush_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == OFS_SETUP) |=> !rd_data[BIT_FLUSH]);
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != OFS_DATA && rd_addr != OFS_RDY && rd_addr != OFS_ERR
     && rd_addr != OFS_IE && rd_addr != OFS_SETUP) |=> (rd_data == '0));
endmodule

// File: tb/tb_uart_rx_poll_regs.sv
`timescale 1ns/1ps
module tb_uart_rx_poll_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        rx_stb, rx_parity_bad;
  logic [7:0]  rx_byte;
  logic        wr_en, rd_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq_rx, irq_err, poll_en;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  uart_rx_poll_regs dut (
    .clk(clk), .rst(rst), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .rx_parity_bad(rx_parity_bad), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_rx(irq_rx), .irq_err(irq_err), .poll_en(poll_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic p);
    rx_stb = 1'b1; rx_byte = b; rx_parity_bad = p;
    @(negedge clk);
    rx_stb = 1'b0; rx_parity_bad = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irqs/poll", {29'd0, irq_rx, irq_err, poll_en}, 0);
    rd(8'h30, v); chk("R1 ready", v, 0);
    rd(8'h28, v); chk("R1 errors", v, 0);
    rd(8'h2C, v); chk("R1 enables", v, 0);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    rx(8'hA5, 1'b0);
    rd(8'h30, v); chk("R2 ready set", v, 1);
    rd(8'h30, v); chk("R3 ready read no side effect", v, 1);
    rd(8'h34, v); chk("R2 data", v, 32'hA5);
    rd(8'h30, v); chk("R3 ready cleared by data read", v, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    rx(8'h11, 1'b0);
    rx(8'h22, 1'b0);
    rd(8'h28, v); chk("R4 overflow bit", v, 1);
    rd(8'h28, v); chk("R6 error read clears", v, 0);
    rd(8'h34, v); chk("R4 newest byte kept", v, 32'h22);
  endtask

  task automatic t_parity;
    logic [31:0] v;
    rx(8'h3C, 1'b1);
    rd(8'h30, v); chk("R5 ready despite parity", v, 1);
    rd(8'h28, v); chk("R5 parity bit", v, 2);
    rd(8'h34, v); chk("R5 byte stored", v, 32'h3C);
    rd(8'h28, v); chk("R6 cleared after read", v, 0);
  endtask

  task automatic t_setwins;
    logic [31:0] v;
    rx(8'h40, 1'b0);
    rx_stb = 1'b1; rx_byte = 8'h41; rx_parity_bad = 1'b0;
    rd_en = 1'b1; rd_addr = 8'h34;
    @(negedge clk);
    rx_stb = 1'b0; rd_en = 1'b0;
    chk("R7 read returns older byte", rd_data, 32'h40);
    rd(8'h30, v); chk("R7 ready stays set", v, 1);
    rd(8'h28, v); chk("R7 no overflow on collision", v, 0);
    rd(8'h34, v); chk("R7 new byte held", v, 32'h41);
    rx(8'h50, 1'b1);
    rd(8'h34, v);
    rx_stb = 1'b1; rx_byte = 8'h51; rx_parity_bad = 1'b1;
    rd_en = 1'b1; rd_addr = 8'h28;
    @(negedge clk);
    rx_stb = 1'b0; rx_parity_bad = 1'b0; rd_en = 1'b0;
    chk("R6 read returns pre-clear value", rd_data, 2);
    rd(8'h28, v); chk("R7 parity set beats clear", v, 2);
    rd(8'h28, v); chk("R6 then cleared", v, 0);
    rd(8'h34, v); chk("R7 byte with error", v, 32'h51);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(8'h2C, 0);
    rx(8'h77, 1'b0);
    chk("R8 rx irq masked", {31'd0, irq_rx}, 0);
    wr(8'h2C, 1);
    chk("R8 rx irq on enable", {31'd0, irq_rx}, 1);
    chk("R8 err irq idle", {31'd0, irq_err}, 0);
    wr(8'h2C, 3);
    rx(8'h78, 1'b0);
    chk("R8 err irq on overflow", {31'd0, irq_err}, 1);
    rd(8'h28, v);
    chk("R8 err irq drops after read", {31'd0, irq_err}, 0);
    rd(8'h34, v);
    chk("R8 rx irq drops after read", {31'd0, irq_rx}, 0);
    rd(8'h2C, v); chk("R8 enable readback", v, 3);
    wr(8'h2C, 0);
  endtask

  task automatic t_setup;
    logic [31:0] v;
    wr(8'h24, 32'h10);
    chk("R9 poll_en", {31'd0, poll_en}, 1);
    rd(8'h24, v); chk("R9 setup readback", v, 32'h10);
    rx(8'h99, 1'b0);
    wr(8'h24, 32'h30);
    rd(8'h30, v); chk("R10 flush clears ready", v, 0);
    rd(8'h34, v); chk("R10 flush discards byte", v, 0);
    rd(8'h24, v); chk("R10 flush bit self clears", v, 32'h10);
    wr_en = 1'b1; wr_addr = 8'h24; wr_data = 32'h30;
    rx_stb = 1'b1; rx_byte = 8'h5A; rx_parity_bad = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; rx_stb = 1'b0;
    rd(8'h30, v); chk("R10 arrival beats flush", v, 1);
    rd(8'h28, v); chk("R10 no overflow on flush collision", v, 0);
    rd(8'h34, v); chk("R10 arrived byte kept", v, 32'h5A);
    wr(8'h24, 0);
    chk("R9 poll_en off", {31'd0, poll_en}, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    rx(8'hC3, 1'b1);
    wr(8'h28, 0);
    wr(8'h30, 0);
    wr(8'h34, 32'hFF);
    rd(8'h30, v); chk("R11 ready unaffected", v, 1);
    rd(8'h28, v); chk("R11 errors unaffected", v, 2);
    rd(8'h34, v); chk("R11 data unaffected", v, 32'hC3);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rx(8'h12, 1'b0);
    rd(8'h3C, v); chk("R12 unmapped 0x3C", v, 0);
    rd(8'h00, v); chk("R12 unmapped 0x00", v, 0);
    rd(8'h30, v); chk("R12 ready intact", v, 1);
    rd(8'h34, v); chk("R12 data intact", v, 32'h12);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_stb = 1'b0; rx_byte = '0; rx_parity_bad = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_capture();
    t_overflow();
    t_parity();
    t_setwins();
    t_irq();
    t_setup();
    t_readonly();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule